// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host issues one request at a time: an address, a write flag and write data, with a valid/ready handshake. The controller turns each request into a sequence of active-low chip-select, output-enable and write-enable strobes. It also drives the address, controls the data-bus driver and returns read data with a single-cycle valid pulse. The data bus reaches the pads as a separate output value, an output-enable and an input value. The tri-state buffer itself sits in the pad ring.

All timing is set in whole clock cycles through parameters: read access cycles, minimum write-pulse cycles and data-setup cycles. Output enable stays high for the whole of every write, so the short write-pulse minimum is enough. The write pulse lasts for the larger of the pulse and data-setup counts, because write data is driven from the first cycle in which write enable is low. Every read begins with a turnaround cycle in which the bus is released before output enable falls. Between operations the RAM is deselected and rests in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, chip select, output enable and write enable are high, the bus driver enable is low, read-valid is low and ready is high.
- R2: Ready is high only when no operation is in progress, and chip select is then high. A request is taken only in a cycle where valid and ready are both high.
- R3: A write drives write enable low, together with chip select low, starting in the cycle after acceptance. It stays low for exactly max(WP_CYC, DS_CYC) consecutive cycles.
- R4: Output enable stays high during every cycle of a write. It goes low only while write enable is high and the bus driver enable is low.
- R5: The bus driver enable and the write data are held from the first write-enable-low cycle through the cycle after write enable rises. The address does not change while chip select is low.
- R6: The first cycle of a read has chip select low, output enable high and the bus driver released.
- R7: After the turnaround cycle, output enable is low for exactly RD_CYC cycles.
- R8: Read data equals the bus input sampled at the clock edge that ends the last output-enable-low cycle. It appears in the next cycle with read-valid high for exactly one cycle, and ready returns high in that same cycle.
- R9: In the cycle after the write-enable-rise cycle, chip select is high, the bus is released and ready is high.
- R10: A request raised while an operation is in progress is ignored. It does not change the address, strobes or bus of the running operation, and it starts no operation afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Read data |
| sram_addr | output | 17 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | 8 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data-bus driver enable |
| sram_dq_in | input | 8 | Value sampled from the data bus |

## Verification
Writes and reads use data values of all zeros, all ones and alternating bit patterns, at the lowest address, the highest address and mid-range addresses. These patterns show a stuck or swapped data or address bit apart from a correct transfer. A write is followed directly by a read of the same location, which exposes a missing turnaround cycle and any overlap of the two bus drivers. A read of an address that was never written shows whether data is taken from the bus or from a stale register. A request raised in the middle of a write separates a controller that ignores it from one that latches it or starts an extra cycle. The bench sets a data-setup count larger than the pulse count, so the pulse-length rule must pick the larger of the two.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_PULSE = 3'd1,
        ST_WR_END   = 3'd2,
        ST_RD_TURN  = 3'd3,
        ST_RD_ACC   = 3'd4
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture_en;
        if (capture_en) cap_d.data = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_valid = cap_q.vld;
    assign rd_data  = cap_q.data;

    // R8: read-valid lasts a single cycle
    p_rdvalid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.vld |=> !cap_q.vld);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int WE_LEN = 2,
    parameter int RD_CYC = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              timer_expired,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              capture_en,
    output logic              req_ready,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);

    localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        timer_load = 1'b0;
        timer_val  = '0;
        capture_en = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr = req_addr;
                    s_d.cs_n = 1'b0;
                    if (req_write) begin
                        s_d.st     = ST_WR_PULSE;
                        s_d.wdata  = req_wdata;
                        s_d.we_n   = 1'b0;
                        s_d.dq_oe  = 1'b1;
                        timer_load = 1'b1;
                        timer_val  = WE_LOAD;
                    end else begin
                        s_d.st = ST_RD_TURN;
                    end
                end
            end
            ST_WR_PULSE: begin
                if (timer_expired) begin
                    s_d.st   = ST_WR_END;
                    s_d.we_n = 1'b1;
                end
            end
            ST_WR_END: begin
                s_d.st    = ST_IDLE;
                s_d.cs_n  = 1'b1;
                s_d.dq_oe = 1'b0;
            end
            ST_RD_TURN: begin
                s_d.st     = ST_RD_ACC;
                s_d.oe_n   = 1'b0;
                timer_load = 1'b1;
                timer_val  = RD_LOAD;
            end
            ST_RD_ACC: begin
                if (timer_expired) begin
                    capture_en = 1'b1;
                    s_d.st     = ST_IDLE;
                    s_d.oe_n   = 1'b1;
                    s_d.cs_n   = 1'b1;
                end
            end
            default: begin
                s_d.st    = ST_IDLE;
                s_d.cs_n  = 1'b1;
                s_d.oe_n  = 1'b1;
                s_d.we_n  = 1'b1;
                s_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.cs_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.dq_oe <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign sram_addr   = s_q.addr;
    assign sram_cs_n   = s_q.cs_n;
    assign sram_oe_n   = s_q.oe_n;
    assign sram_we_n   = s_q.we_n;
    assign sram_dq_out = s_q.wdata;
    assign sram_dq_oe  = s_q.dq_oe;

    // R2: ready only with the RAM deselected
    p_ready_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_cs_n);

    // R4: output enable low only with WE high and the bus released
    p_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (sram_we_n && !sram_dq_oe));

    // R3: a write strobe only inside chip select
    p_we_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_cs_n);

    // R5: address steady while selected
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    // R5: data still driven in the cycle write enable rises
    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sram_we_n) && !sram_cs_n) |-> (sram_dq_oe && $stable(sram_dq_out)));

    // R6: output enable falls only after a cycle with the bus released
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> $past(!sram_cs_n && !sram_dq_oe && sram_we_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 2,
    parameter int WP_CYC = 2,
    parameter int DS_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int WE_LEN  = int'(max_u(WP_CYC, DS_CYC));
    localparam int MAX_LEN = int'(max_u(WE_LEN, RD_CYC));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expired;
    logic             capture_en;

    sram_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WE_LEN (WE_LEN),
        .RD_CYC (RD_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .timer_expired (timer_expired),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .capture_en    (capture_en),
        .req_ready     (req_ready),
        .sram_addr     (sram_addr),
        .sram_cs_n     (sram_cs_n),
        .sram_oe_n     (sram_oe_n),
        .sram_we_n     (sram_we_n),
        .sram_dq_out   (sram_dq_out),
        .sram_dq_oe    (sram_dq_oe)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .bus_in     (sram_dq_in),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    // R8: a capture happens only while the RAM is being read
    p_capture_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |-> (!sram_cs_n && !sram_oe_n));

    // R10: no operation starts while one runs
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !sram_cs_n) |=> (sram_cs_n || $stable(sram_addr)));

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD_CYC = 2;
    localparam int WP_CYC = 2;
    localparam int DS_CYC = 3;
    localparam int WE_LEN = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid, sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] rd_data, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .RD_CYC (RD_CYC), .WP_CYC (WP_CYC), .DS_CYC (DS_CYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .sram_addr (sram_addr), .sram_cs_n (sram_cs_n), .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n), .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe),
        .sram_dq_in (sram_dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM model ----------------
    logic [DW-1:0] ram [256];
    logic [DW-1:0] exp_mem [256];
    logic ram_drv;
    int   we_cnt = 0;
    logic prev_we_low = 1'b0, prev_dq_oe = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]     = DW'(i) ^ 8'h3C;
            exp_mem[i] = DW'(i) ^ 8'h3C;
        end
    end

    assign ram_drv    = !sram_cs_n && !sram_oe_n && sram_we_n;
    assign sram_dq_in = ram_drv ? ram[sram_addr[7:0]] : 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_drv && sram_dq_oe) chk("R4 bus contention", 1, 0);
            if (!sram_oe_n && prev_dq_oe) chk("R6 no turnaround", 1, 0);
            if (!sram_we_n) begin
                if (sram_cs_n) chk("R3 WE outside CS", 1, 0);
                if (prev_we_low && (sram_addr !== prev_addr || sram_dq_out !== prev_dout))
                    chk("R5 addr/data moved in pulse", 1, 0);
                we_cnt++;
            end else if (prev_we_low) begin
                if (we_cnt != WE_LEN) chk("R3 model pulse length", we_cnt, WE_LEN);
                if (!sram_dq_oe || sram_dq_out !== prev_dout) chk("R5 model data hold", 1, 0);
                if (!sram_cs_n) ram[sram_addr[7:0]] = sram_dq_out;
                we_cnt = 0;
            end
            prev_we_low = !sram_we_n;
            prev_dq_oe  = sram_dq_oe;
            prev_addr   = sram_addr;
            prev_dout   = sram_dq_out;
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3 WE low first cycle", sram_we_n, 0);
        chk("R3 CS low in write", sram_cs_n, 0);
        chk("R4 OE high in write", sram_oe_n, 1);
        chk("R5 bus driven", sram_dq_oe, 1);
        chk("R5 write data", sram_dq_out, d);
        chk("R5 write addr", sram_addr, a);
        chk("R2 ready low while busy", req_ready, 0);
        for (int i = 1; i < WE_LEN; i++) begin
            if (poke && i == 1) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = ~a; req_wdata = ~d;
            end
            @(negedge clk);
            if (poke && i == 1) begin
                req_valid = 1'b0;
                chk("R10 addr kept", sram_addr, a);
                chk("R10 data kept", sram_dq_out, d);
            end
            chk("R3 WE still low", sram_we_n, 0);
            chk("R4 OE high in pulse", sram_oe_n, 1);
        end
        @(negedge clk);
        chk("R3 WE high after pulse", sram_we_n, 1);
        chk("R5 CS held after WE", sram_cs_n, 0);
        chk("R5 data held after WE", sram_dq_oe, 1);
        @(negedge clk);
        chk("R9 CS high after write", sram_cs_n, 1);
        chk("R9 bus released", sram_dq_oe, 0);
        chk("R9 ready back", req_ready, 1);
        exp_mem[a[7:0]] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 CS low turn", sram_cs_n, 0);
        chk("R6 OE high turn", sram_oe_n, 1);
        chk("R6 bus released turn", sram_dq_oe, 0);
        chk("R6 addr", sram_addr, a);
        chk("R2 ready low in read", req_ready, 0);
        for (int i = 0; i < RD_CYC; i++) begin
            @(negedge clk);
            chk("R7 OE low", sram_oe_n, 0);
            chk("R8 no early valid", rd_valid, 0);
        end
        @(negedge clk);
        chk("R8 rd_valid", rd_valid, 1);
        chk("R8 rd_data", rd_data, exp_mem[a[7:0]]);
        chk("R7 OE high after access", sram_oe_n, 1);
        chk("R8 ready with valid", req_ready, 1);
        chk("R2 standby after read", sram_cs_n, 1);
        @(negedge clk);
        chk("R8 single pulse", rd_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n in reset", sram_cs_n, 1);
        chk("R1 oe_n in reset", sram_oe_n, 1);
        chk("R1 we_n in reset", sram_we_n, 1);
        chk("R1 dq_oe in reset", sram_dq_oe, 0);
        chk("R1 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n after reset", sram_cs_n, 1);
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 oe_n after reset", sram_oe_n, 1);
    endtask

    task automatic t_idle_no_request();
        repeat (3) begin
            @(negedge clk);
            chk("R2 idle standby", sram_cs_n, 1);
            chk("R2 idle ready", req_ready, 1);
        end
    endtask

    task automatic t_patterns();
        do_write(17'h00000, 8'h00, 1'b0);
        do_write(17'h1FFFF, 8'hFF, 1'b0);
        do_write(17'h0AA55, 8'hA5, 1'b0);
        do_write(17'h15501, 8'h5A, 1'b0);
        do_read(17'h00000);
        do_read(17'h1FFFF);
        do_read(17'h0AA55);
        do_read(17'h15501);
    endtask

    task automatic t_write_then_read();
        do_write(17'h12377, 8'hC3, 1'b0);
        do_read(17'h12377);
        do_write(17'h12377, 8'h3C, 1'b0);
        do_read(17'h12377);
    endtask

    task automatic t_unwritten();
        do_read(17'h00042);
    endtask

    task automatic t_busy_ignore();
        do_write(17'h04410, 8'h96, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R10 no extra op", sram_cs_n, 1);
        end
        do_read(17'h04410);
        do_read(17'h1BBEF);
    endtask

    initial begin
        t_reset();
        t_idle_no_request();
        t_patterns();
        t_write_then_read();
        t_unwritten();
        t_busy_ignore();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule